// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B. Each bus has its own storage register, and each register has its own capture clock. Either bus can be driven with live data from the other bus, or with the value that was last stored from the other bus. Capture never pauses. Each register samples its bus on every rising edge of its clock, whether or not any output is enabled.

One active-low enable and one direction input choose which bus, if any, the block drives. Each bus has its own select input. The select picks pass-through (the live opposite bus) or stored data (the opposite bus's register). There are no pads. Each bus has a separate input, output and output-enable, so the surrounding logic, or a testbench, can build the tri-state net from them. The output path is purely combinational. A change to the enable, direction or selects takes effect without any clock edge.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising edge of `clk_a` the A register loads `a_in`. On a rising edge of `clk_b` the B register loads `b_in`.
- R2: Register capture does not depend on `oe_n`, `dir_a2b` or the selects. Data clocked in while both buses are isolated shows up later in stored mode.
- R3: When `oe_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both 0.
- R4: When `oe_n` is 0 and `dir_a2b` is 1, `b_oe` is 1, `a_oe` is 0 and `a_out` is 0.
- R5: When `oe_n` is 0 and `dir_a2b` is 0, `a_oe` is 1, `b_oe` is 0 and `b_out` is 0.
- R6: When B is driven and `sel_a2b_reg` is 0, `b_out` equals the current `a_in`.
- R7: When B is driven and `sel_a2b_reg` is 1, `b_out` equals the A register. After a `clk_a` edge it shows the value just captured.
- R8: When A is driven and `sel_b2a_reg` is 0, `a_out` equals the current `b_in`.
- R9: When A is driven and `sel_b2a_reg` is 1, `a_out` equals the B register. After a `clk_b` edge it shows the value just captured.
- R10: A change to `oe_n`, `dir_a2b` or either select changes the outputs with no clock edge.
- R11: With the default `USE_SRST` = 1, `srst_a` high at a rising `clk_a` edge clears the A register to 0. `srst_b` does the same for the B register on `clk_b`. Neither reset touches the other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A register |
| srst_a | input | 1 | Synchronous clear of the A register, active high |
| clk_b | input | 1 | Capture clock of the B register |
| srst_b | input | 1 | Synchronous clear of the B register, active high |
| oe_n | input | 1 | Output enable, active low; 1 isolates both buses |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_a2b_reg | input | 1 | A-to-B source: 0 live A bus, 1 A register |
| sel_b2a_reg | input | 1 | B-to-A source: 0 live B bus, 1 B register |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Value driven onto the A bus (0 when not driven) |
| a_oe | output | 1 | A bus driver enable |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Value driven onto the B bus (0 when not driven) |
| b_oe | output | 1 | B bus driver enable |

## Verification
Results controlled by the enable, direction and selects, and pass-through data, are combinational. The bench samples them a few nanoseconds after changing an input, with no clock edge in between. A stored-mode result is due right after the single capture edge of the relevant register clock. The bench pulses that clock once, waits past the edge, then compares. The checker relates `b_out` and `a_out` at each capture edge to the bus value sampled at the previous edge of the same clock.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

   // Which bus the transceiver is currently driving
   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_A    = 2'd1,
      DRV_B    = 2'd2
   } drv_e;

   function automatic drv_e decode_drive(input logic oe_n, input logic dir_a2b);
      if (oe_n)
         return DRV_NONE;
      else if (dir_a2b)
         return DRV_B;
      else
         return DRV_A;
   endfunction

endpackage

// File: rtl/xcvr_cap_reg.sv
// One capture register. It samples its bus on every rising clock edge.
module xcvr_cap_reg #(
   parameter int   WIDTH    = 8,
   parameter bit   USE_SRST = 1'b1,
   parameter logic [WIDTH-1:0] CLR_VAL = '0
) (
   input  logic             clk,
   input  logic             srst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_cap_reg: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] store_q;

   if (USE_SRST) begin : g_srst
      always_ff @(posedge clk) begin
         if (srst)
            store_q <= CLR_VAL;
         else
            store_q <= d;
      end
   end else begin : g_nosrst
      logic unused_srst;
      assign unused_srst = srst;
      always_ff @(posedge clk) begin
         store_q <= d;
      end
   end

   assign q = store_q;

endmodule

// File: rtl/xcvr_drive_ctl.sv
// Turns the enable and direction inputs into one driver enable per bus.
module xcvr_drive_ctl
   import regbus_xcvr_pkg::*;
(
   input  logic oe_n,
   input  logic dir_a2b,
   output logic drive_a,
   output logic drive_b
);

   drv_e state;

   always_comb begin
      state   = decode_drive(oe_n, dir_a2b);
      drive_a = 1'b0;
      drive_b = 1'b0;
      unique case (state)
         DRV_A:   drive_a = 1'b1;
         DRV_B:   drive_b = 1'b1;
         default: begin
            drive_a = 1'b0;
            drive_b = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/xcvr_path_mux.sv
// One direction of the data path: picks live or stored data, and gates it with the driver enable.
module xcvr_path_mux #(
   parameter int WIDTH     = 8,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic             en,
   input  logic             sel_reg,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] dout,
   output logic             oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_path_mux: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] src;

   always_comb begin
      src = sel_reg ? stored : live;
   end

   if (ZERO_IDLE) begin : g_zero_idle
      assign dout = en ? src : '0;
   end else begin : g_pass_idle
      assign dout = src;
   end

   assign oe = en;

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int WIDTH     = 8,
   parameter bit USE_SRST  = 1'b1,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic             clk_a,
   input  logic             srst_a,
   input  logic             clk_b,
   input  logic             srst_b,
   input  logic             oe_n,
   input  logic             dir_a2b,
   input  logic             sel_a2b_reg,
   input  logic             sel_b2a_reg,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   localparam logic [WIDTH-1:0] CLR_VAL = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("regbus_xcvr: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] reg_a_q;
   logic [WIDTH-1:0] reg_b_q;
   logic             drive_a;
   logic             drive_b;

   // A register captures the A bus on clk_a
   xcvr_cap_reg #(
      .WIDTH    (WIDTH),
      .USE_SRST (USE_SRST),
      .CLR_VAL  (CLR_VAL)
   ) u_reg_a (
      .clk  (clk_a),
      .srst (srst_a),
      .d    (a_in),
      .q    (reg_a_q)
   );

   // B register captures the B bus on clk_b
   xcvr_cap_reg #(
      .WIDTH    (WIDTH),
      .USE_SRST (USE_SRST),
      .CLR_VAL  (CLR_VAL)
   ) u_reg_b (
      .clk  (clk_b),
      .srst (srst_b),
      .d    (b_in),
      .q    (reg_b_q)
   );

   xcvr_drive_ctl u_ctl (
      .oe_n    (oe_n),
      .dir_a2b (dir_a2b),
      .drive_a (drive_a),
      .drive_b (drive_b)
   );

   // B bus is fed from the A side
   xcvr_path_mux #(
      .WIDTH     (WIDTH),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_to_b (
      .en      (drive_b),
      .sel_reg (sel_a2b_reg),
      .live    (a_in),
      .stored  (reg_a_q),
      .dout    (b_out),
      .oe      (b_oe)
   );

   // A bus is fed from the B side
   xcvr_path_mux #(
      .WIDTH     (WIDTH),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_to_a (
      .en      (drive_a),
      .sel_reg (sel_b2a_reg),
      .live    (b_in),
      .stored  (reg_b_q),
      .dout    (a_out),
      .oe      (a_oe)
   );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk_a,
   input logic             srst_a,
   input logic             clk_b,
   input logic             srst_b,
   input logic             oe_n,
   input logic             dir_a2b,
   input logic             sel_a2b_reg,
   input logic             sel_b2a_reg,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);

   // R3
   isolate_chk: assert property (@(posedge clk_a) disable iff (srst_a)
      oe_n |-> (!a_oe && !b_oe));

   // R4
   drive_b_chk: assert property (@(posedge clk_a) disable iff (srst_a)
      (!oe_n && dir_a2b) |-> (b_oe && !a_oe));

   // R5
   drive_a_chk: assert property (@(posedge clk_b) disable iff (srst_b)
      (!oe_n && !dir_a2b) |-> (a_oe && !b_oe));

   // R6
   pass_a2b_chk: assert property (@(posedge clk_a) disable iff (srst_a)
      (!oe_n && dir_a2b && !sel_a2b_reg) |-> (b_out == a_in));

   // R7
   stored_a2b_chk: assert property (@(posedge clk_a) disable iff (srst_a)
      (!$past(srst_a) && !oe_n && dir_a2b && sel_a2b_reg) |-> (b_out == $past(a_in)));

   // R8
   pass_b2a_chk: assert property (@(posedge clk_b) disable iff (srst_b)
      (!oe_n && !dir_a2b && !sel_b2a_reg) |-> (a_out == b_in));

   // R9
   stored_b2a_chk: assert property (@(posedge clk_b) disable iff (srst_b)
      (!$past(srst_b) && !oe_n && !dir_a2b && sel_b2a_reg) |-> (a_out == $past(b_in)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_a       (clk_a),
   .srst_a      (srst_a),
   .clk_b       (clk_b),
   .srst_b      (srst_b),
   .oe_n        (oe_n),
   .dir_a2b     (dir_a2b),
   .sel_a2b_reg (sel_a2b_reg),
   .sel_b2a_reg (sel_b2a_reg),
   .a_in        (a_in),
   .a_out       (a_out),
   .a_oe        (a_oe),
   .b_in        (b_in),
   .b_out       (b_out),
   .b_oe        (b_oe)
);

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb;

   localparam int W = 8;

   logic         clk;
   logic         clk_a, clk_b, srst_a, srst_b;
   logic         oe_n, dir_a2b, sel_a2b_reg, sel_b2a_reg;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         a_oe, b_oe;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   regbus_xcvr #(.WIDTH(W)) u_dut (
      .clk_a(clk_a), .srst_a(srst_a), .clk_b(clk_b), .srst_b(srst_b),
      .oe_n(oe_n), .dir_a2b(dir_a2b),
      .sel_a2b_reg(sel_a2b_reg), .sel_b2a_reg(sel_b2a_reg),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   // 50 MHz reference clock for the watchdog
   initial clk = 1'b0;
   always #10 clk = ~clk;

   // Vector fields: ctl{oe_n,dir,sel_a2b,sel_b2a}, a_in, b_in, pulse{a,b}, exp_oe{a,b}, exp_a_out, exp_b_out
   localparam int NV = 12;
   localparam logic [39:0] VEC [NV] = '{
      {4'b1000, 8'h11, 8'h22, 2'b11, 2'b00, 8'h00, 8'h00}, // R2 R3: capture while isolated
      {4'b0110, 8'h33, 8'h44, 2'b00, 2'b01, 8'h00, 8'h11}, // R7 R4: stored A to B
      {4'b0110, 8'h55, 8'h44, 2'b10, 2'b01, 8'h00, 8'h55}, // R7 R1: new capture shown
      {4'b0100, 8'h66, 8'h77, 2'b00, 2'b01, 8'h00, 8'h66}, // R6 R10: pass-through
      {4'b0001, 8'h88, 8'h99, 2'b00, 2'b10, 8'h22, 8'h00}, // R9 R5: stored B to A
      {4'b0001, 8'h88, 8'hAA, 2'b01, 2'b10, 8'hAA, 8'h00}, // R9 R1
      {4'b0000, 8'h88, 8'hBB, 2'b00, 2'b10, 8'hBB, 8'h00}, // R8
      {4'b1111, 8'hC1, 8'hD2, 2'b11, 2'b00, 8'h00, 8'h00}, // R2 R3
      {4'b0011, 8'h00, 8'h00, 2'b00, 2'b10, 8'hD2, 8'h00}, // R2 R9
      {4'b0111, 8'h00, 8'h00, 2'b00, 2'b01, 8'h00, 8'hC1}, // R2 R7 R10
      {4'b0010, 8'hE3, 8'hF4, 2'b00, 2'b10, 8'hF4, 8'h00}, // R8 R10
      {4'b0101, 8'hE3, 8'hF4, 2'b00, 2'b01, 8'h00, 8'hE3}  // R6 R10
   };

   task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic pulse_a();
      clk_a = 1'b1; #4; clk_a = 1'b0; #2;
   endtask

   task automatic pulse_b();
      clk_b = 1'b1; #4; clk_b = 1'b0; #2;
   endtask

   task automatic set_ctl(input logic [3:0] c);
      {oe_n, dir_a2b, sel_a2b_reg, sel_b2a_reg} = c;
   endtask

   task automatic check_all(input string req, input logic eao, input logic ebo,
                            input logic [W-1:0] ea, input logic [W-1:0] eb);
      chk(req, "a_oe",  W'(a_oe), W'(eao));
      chk(req, "b_oe",  W'(b_oe), W'(ebo));
      chk(req, "a_out", a_out, ea);
      chk(req, "b_out", b_out, eb);
   endtask

   // Watchdog
   initial begin
      #(20 * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ma, mb;
      clk_a = 0; clk_b = 0; srst_a = 1; srst_b = 1;
      set_ctl(4'b1000); a_in = 8'h5A; b_in = 8'hA5;
      #3;
      pulse_a(); pulse_b(); pulse_a(); pulse_b();
      srst_a = 0; srst_b = 0;
      #3;
      // R11: reset state of both registers, seen through stored mode
      set_ctl(4'b0110); #3;
      chk("R11", "b_out after reset", b_out, 8'h00);
      set_ctl(4'b0001); #3;
      chk("R11", "a_out after reset", a_out, 8'h00);
      set_ctl(4'b1000); #3;
      check_all("R3", 1'b0, 1'b0, 8'h00, 8'h00);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         v = VEC[i];
         set_ctl(v[39:36]);
         a_in = v[35:28];
         b_in = v[27:20];
         #3;
         if (v[19]) pulse_a();
         if (v[18]) pulse_b();
         #2;
         check_all($sformatf("R1-vec%0d", i), v[17], v[16], v[15:8], v[7:0]);
      end

      // Sweep of all control combinations, with and without capture edges
      ma = 8'hE3; mb = 8'hD2;
      set_ctl(4'b1000); a_in = ma; b_in = mb; #2; pulse_a(); pulse_b();
      for (int c = 0; c < 16; c++) begin
         for (int p = 0; p < 2; p++) begin
            logic [3:0] cc;
            logic [W-1:0] ea, eb;
            logic eao, ebo;
            string tag;
            cc = 4'(c);
            set_ctl(cc);
            a_in = 8'(c * 17 + p * 5 + 3);
            b_in = 8'(c * 29 + p * 11 + 7);
            #3;
            if (p == 1) begin
               pulse_a(); pulse_b();
               ma = a_in; mb = b_in;
            end
            #2;
            eao = 0; ebo = 0; ea = '0; eb = '0;
            if (cc[3]) tag = "R3";
            else if (cc[2]) begin
               ebo = 1; eb = cc[1] ? ma : a_in; tag = cc[1] ? "R7" : "R6";
            end else begin
               eao = 1; ea = cc[0] ? mb : b_in; tag = cc[0] ? "R9" : "R8";
            end
            check_all(tag, eao, ebo, ea, eb);
         end
      end

      // R11: reset one register only, the other keeps its value
      set_ctl(4'b1000); a_in = 8'h3C; b_in = 8'hC3; #2;
      pulse_a(); pulse_b();
      srst_a = 1; #2; pulse_a(); srst_a = 0; #2;
      set_ctl(4'b0110); #3;
      chk("R11", "A cleared", b_out, 8'h00);
      set_ctl(4'b0001); #3;
      chk("R11", "B kept", a_out, 8'hC3);

      // R10: select flip with no clock edge
      set_ctl(4'b0000); #3;
      chk("R10", "live b", a_out, 8'hC3);
      b_in = 8'h0F; #3;
      chk("R8", "live b follows", a_out, 8'h0F);
      set_ctl(4'b0001); #3;
      chk("R10", "stored b", a_out, 8'hC3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule